// File: doc/BRIEF.md
# DMA Completion and Error Status Unit

This unit keeps the completion and bus-error bookkeeping for an eight-channel DMA controller. The transfer engine sends it a one-cycle completion pulse and a level activity flag for each channel, plus a one-cycle pulse when a bus error occurs. Each completion sets a sticky per-channel bit. The bit stays set until software clears it by writing a one. The bus error works the same way, with a single sticky flag.

A per-channel steering mask decides where each channel's completion goes:

- **Mask bit 0:** the channel's completion pulse and activity flag are forwarded to the peripheral that owns the channel. The channel takes no part in the combined completion output.
- **Mask bit 1:** the peripheral sees nothing from that channel. Its sticky completion bit instead feeds one combined completion line. This suits channels that software starts itself.

Software uses a small write/read register port. Writes take effect at the clock edge where `reg_wr_en` is high. Reads return their value one cycle after `reg_rd_en`.

Top module: `dma_cmpl_unit`

## Requirements
- R1: After a synchronous active-low reset, all sticky completion bits, all mask bits and the error flag are zero, and every output is low.
- R2: A pulse on `ch_done_in[c]` sets sticky completion bit c at that clock edge. The bit then stays set with no further pulse. Software reads the completion bits at offset 0x504, in bits [7:0], bit c for channel c.
- R3: Writing offset 0x504 clears each completion bit whose data bit is 1. Bits written with 0 keep their value.
- R4: When a completion pulse and a software clear hit the same bit at the same edge, the bit ends up set.
- R5: Writing offset 0x520 loads the steering mask from data bits [7:0], bit c for channel c. Reading that offset returns the mask.
- R6: With mask bit c at 0, `periph_done[c]` and `periph_active[c]` repeat `ch_done_in[c]` and `ch_active_in[c]` one cycle later. Channel c does not drive `combined_done`.
- R7: With mask bit c at 1, `periph_done[c]` and `periph_active[c]` stay low one cycle later, whatever the engine drives.
- R8: `combined_done` is high exactly when some channel has both its sticky completion bit and its mask bit set. It follows register changes in the same cycle they occur.
- R9: A pulse on `bus_err_in` sets `err_flag`. The flag reads as bit 0 of offset 0x04C. Writing that offset with data bit 0 at 1 clears the flag, writing 0 leaves it set, and a simultaneous error pulse wins over the clear.
- R10: Read data is registered. It appears one cycle after `reg_rd_en` and holds until the next read. Unused upper bits read as zero, and an unmapped offset reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ch_done_in | input | 8 | Per-channel completion pulses from the engine |
| ch_active_in | input | 8 | Per-channel activity flags from the engine |
| bus_err_in | input | 1 | Bus error pulse |
| periph_done | output | 8 | Completion pulses forwarded to peripherals |
| periph_active | output | 8 | Activity flags forwarded to peripherals |
| combined_done | output | 1 | OR of masked sticky completion bits |
| err_flag | output | 1 | Sticky bus error flag |

## Verification
Each result has its own latency, and every check is timed to it:

- Sticky bits, the mask and the error flag change at the edge that samples their stimulus.
- `combined_done` and `err_flag` are visible right after that edge.
- Peripheral lines and read data lag their stimulus by exactly one register stage.

A behavioural reference model in the bench updates on the same edges. Every output is compared with the model at each falling edge, so every latency is checked in every cycle. Directed sequences place completion pulses, clears, mask changes and error pulses so that each outcome is read back at the one cycle where it is due.

// File: rtl/dcs_pkg.sv
// Package: shared sizes, register offsets and the decode of the register port.
// Assumes byte offsets arrive on a 12-bit address.
package dcs_pkg;
    localparam int unsigned CH_NUM = 8;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ERR  = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_DONE = 12'h504;
    localparam logic [ADDR_W-1:0] OFS_MASK = 12'h520;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ERR  = 2'd1,
        SEL_DONE = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_ERR:  s = SEL_ERR;
            OFS_DONE: s = SEL_DONE;
            OFS_MASK: s = SEL_MASK;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dcs_sticky.sv
// Module: bank of sticky bits, set by event pulses and cleared by
// write-one-to-clear strobes. A set and a clear on the same bit in the
// same cycle leave the bit set. Assumes pulses are already synchronous to clk.
module dcs_sticky #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] bits_o
);
    logic [WIDTH-1:0] bits_q;

    // Purpose: hold each bit, clear on strobe, give priority to a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= (bits_q & ~clr_i) | set_i;
    end

    assign bits_o = bits_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        // R2 / R4: an event always leaves the bit set, even against a clear
        a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> bits_o[i]);
        // R2: without set or clear the bit keeps its value
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[i] && !clr_i[i]) |=> (bits_o[i] == $past(bits_o[i])));
        // R3: clear without set empties the bit
        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !bits_o[i]);
    end
endmodule

// File: rtl/dcs_steer.sv
// Module: steering mask and routing. Holds the mask, forwards completion
// pulses and activity flags of unmasked channels to peripherals through one
// register stage, and ORs sticky completion of masked channels into one line.
// Assumes the mask write strobe comes from the register decoder.
module dcs_steer #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_wdata_i,
    input  logic [N-1:0] done_pulse_i,
    input  logic [N-1:0] active_i,
    input  logic [N-1:0] done_bits_i,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] pdone_o,
    output logic [N-1:0] pactive_o,
    output logic         comb_o
);
    logic [N-1:0] mask_q;
    logic [N-1:0] pdone_q;
    logic [N-1:0] pactive_q;
    logic [N-1:0] contrib;

    // Purpose: load the steering mask on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    // Purpose: register the peripheral-facing lines of unmasked channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdone_q   <= '0;
            pactive_q <= '0;
        end else begin
            pdone_q   <= done_pulse_i & ~mask_q;
            pactive_q <= active_i & ~mask_q;
        end
    end

    // Purpose: select which sticky bits may raise the combined line.
    always_comb begin
        for (int c = 0; c < N; c++) contrib[c] = done_bits_i[c] & mask_q[c];
    end

    assign comb_o    = |contrib;
    assign mask_o    = mask_q;
    assign pdone_o   = pdone_q;
    assign pactive_o = pactive_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6: an unmasked completion reaches the peripheral one cycle later
        a_r6_pass_done: assert property (@(posedge clk) disable iff (!rst_n)
            (!mask_q[i] && done_pulse_i[i]) |=> pdone_o[i]);
        // R7: a masked channel never reaches its peripheral
        a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[i] |=> (!pdone_o[i] && !pactive_o[i]));
    end
    // R8: with no channel steered to it the combined line stays low
    a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !comb_o);
endmodule

// File: rtl/dcs_regif.sv
// Module: register port decoder. Turns writes into clear strobes and a mask
// load, and returns read data one cycle after a read strobe.
// Assumes at most one register is addressed per cycle.
module dcs_regif
    import dcs_pkg::*;
#(
    parameter int unsigned N  = CH_NUM,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  done_bits_i,
    input  logic [N-1:0]  mask_i,
    input  logic          err_i,
    output logic [N-1:0]  done_clr_o,
    output logic          err_clr_o,
    output logic          mask_we_o,
    output logic [N-1:0]  mask_wdata_o,
    output logic [DW-1:0] rdata_o
);
    localparam int unsigned PAD_W = DW - N;

    reg_sel_e      sel;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;
    logic          unused_wdata;

    assign sel          = decode_ofs(addr_i);
    assign unused_wdata = ^wdata_i[DW-1:N];

    // Purpose: derive write strobes for the addressed register.
    always_comb begin
        done_clr_o   = '0;
        err_clr_o    = 1'b0;
        mask_we_o    = 1'b0;
        mask_wdata_o = wdata_i[N-1:0];
        if (wr_en_i) begin
            unique case (sel)
                SEL_DONE: done_clr_o = wdata_i[N-1:0];
                SEL_ERR:  err_clr_o  = wdata_i[0];
                SEL_MASK: mask_we_o  = 1'b1;
                default:  ;
            endcase
        end
    end

    // Purpose: choose the read value, zero-extended.
    always_comb begin
        unique case (sel)
            SEL_DONE: rd_mux = {{PAD_W{1'b0}}, done_bits_i};
            SEL_MASK: rd_mux = {{PAD_W{1'b0}}, mask_i};
            SEL_ERR:  rd_mux = {{(DW-1){1'b0}}, err_i};
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

    // R10: a read of an unmapped offset returns zero
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel == SEL_NONE) |=> (rdata_o == '0));
    // R10: read data holds between reads
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
    // R3: no clear strobe appears without a write
    a_r3_no_stray_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |-> (done_clr_o == '0 && !err_clr_o));
endmodule

// File: rtl/dma_cmpl_unit.sv
// Module: top of the DMA completion and error status unit. Combines the
// register decoder, the sticky completion bank, the sticky error flag and the
// steering logic. Assumes engine pulses are one cycle wide and synchronous.
module dma_cmpl_unit
    import dcs_pkg::*;
#(
    parameter int unsigned N  = CH_NUM,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic          reg_rd_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [N-1:0]  ch_done_in,
    input  logic [N-1:0]  ch_active_in,
    input  logic          bus_err_in,
    output logic [N-1:0]  periph_done,
    output logic [N-1:0]  periph_active,
    output logic          combined_done,
    output logic          err_flag
);
    logic [N-1:0] done_bits;
    logic [N-1:0] done_clr;
    logic [N-1:0] mask;
    logic [N-1:0] mask_wdata;
    logic         mask_we;
    logic         err_clr;
    logic [0:0]   err_bits;

    dcs_regif #(.N(N), .AW(AW), .DW(DW)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(reg_wr_en), .rd_en_i(reg_rd_en),
        .addr_i(reg_addr), .wdata_i(reg_wdata),
        .done_bits_i(done_bits), .mask_i(mask), .err_i(err_bits[0]),
        .done_clr_o(done_clr), .err_clr_o(err_clr),
        .mask_we_o(mask_we), .mask_wdata_o(mask_wdata),
        .rdata_o(reg_rdata)
    );

    dcs_sticky #(.WIDTH(N)) u_done_bank (
        .clk(clk), .rst_n(rst_n),
        .set_i(ch_done_in), .clr_i(done_clr), .bits_o(done_bits)
    );

    dcs_sticky #(.WIDTH(1)) u_err_bank (
        .clk(clk), .rst_n(rst_n),
        .set_i(bus_err_in), .clr_i(err_clr), .bits_o(err_bits)
    );

    dcs_steer #(.N(N)) u_steer (
        .clk(clk), .rst_n(rst_n),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
        .done_pulse_i(ch_done_in), .active_i(ch_active_in),
        .done_bits_i(done_bits), .mask_o(mask),
        .pdone_o(periph_done), .pactive_o(periph_active),
        .comb_o(combined_done)
    );

    assign err_flag = err_bits[0];

    // R9: a bus error pulse always leaves the flag set
    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_in |=> err_flag);
    // R8: a fresh completion on a steered channel raises the combined line
    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_done_in & mask) != '0 && !mask_we) |=> combined_done);
    // R1: the cycle after reset everything is clear
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (done_bits == '0 && mask == '0 && !err_flag && periph_done == '0));
endmodule

// File: tb/dma_cmpl_unit_bench.sv
module dma_cmpl_unit_bench;
    localparam int N = 8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] ch_done_in = '0, ch_active_in = '0;
    logic        bus_err_in = 1'b0;
    logic [N-1:0] periph_done, periph_active;
    logic        combined_done, err_flag;

    int compared = 0, mismatched = 0, cycles = 0;
    bit model_ok = 0;

    // reference model state
    logic [N-1:0] m_done, m_mask, m_pd, m_pa;
    logic         m_err;
    logic [31:0]  m_rdata;

    dma_cmpl_unit u_dma_cmpl_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_done_in(ch_done_in), .ch_active_in(ch_active_in), .bus_err_in(bus_err_in),
        .periph_done(periph_done), .periph_active(periph_active),
        .combined_done(combined_done), .err_flag(err_flag)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    // reference model, behavioural from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_done = '0; m_mask = '0; m_pd = '0; m_pa = '0; m_err = 0; m_rdata = '0;
            model_ok = 1;
        end else begin
            logic [31:0] rv;
            if (reg_addr == 12'h504)      rv = {24'h0, m_done};
            else if (reg_addr == 12'h520) rv = {24'h0, m_mask};
            else if (reg_addr == 12'h04C) rv = {31'h0, m_err};
            else                          rv = 32'h0;
            if (reg_rd_en) m_rdata = rv;
            m_pd = ch_done_in & ~m_mask;
            m_pa = ch_active_in & ~m_mask;
            if (reg_wr_en && reg_addr == 12'h504) m_done = m_done & ~reg_wdata[7:0];
            m_done = m_done | ch_done_in;
            if (reg_wr_en && reg_addr == 12'h04C && reg_wdata[0]) m_err = 0;
            if (bus_err_in) m_err = 1;
            if (reg_wr_en && reg_addr == 12'h520) m_mask = reg_wdata[7:0];
        end
    end

    // compare every output against the model at each falling edge
    always @(negedge clk) begin
        cycles++;
        if (model_ok) begin
            check("R6/R7 periph_done", {24'h0, periph_done}, {24'h0, m_pd});
            check("R6/R7 periph_active", {24'h0, periph_active}, {24'h0, m_pa});
            check("R8 combined_done", {31'h0, combined_done}, {31'h0, |(m_done & m_mask)});
            check("R9 err_flag", {31'h0, err_flag}, {31'h0, m_err});
            check("R10 reg_rdata", reg_rdata, m_rdata);
        end
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd_en = 1; reg_addr = a;
        @(negedge clk); reg_rd_en = 0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] dn, input logic [N-1:0] act);
        @(negedge clk); ch_done_in = dn; ch_active_in = act;
        @(negedge clk); ch_done_in = '0; ch_active_in = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 periph_done", {24'h0, periph_done}, 0);
        check("R1 combined_done", {31'h0, combined_done}, 0);
        check("R1 err_flag", {31'h0, err_flag}, 0);
        rst_n = 1;
        rd(12'h504, v); check("R1 done bits", v, 0);
        rd(12'h520, v); check("R1 mask", v, 0);

        // R6: unmasked completion goes to peripheral one cycle later
        pulse(8'h04, 8'h04);
        check("R6 periph_done ch2", {24'h0, periph_done}, 32'h04);
        check("R6 periph_active ch2", {24'h0, periph_active}, 32'h04);
        check("R6 combined excluded", {31'h0, combined_done}, 0);
        rd(12'h504, v); check("R2 sticky ch2", v, 32'h04);
        repeat (3) @(negedge clk);
        rd(12'h504, v); check("R2 sticky holds", v, 32'h04);

        // R3: write zero no effect, write one clears
        wr(12'h504, 32'h0);   rd(12'h504, v); check("R3 zero write", v, 32'h04);
        wr(12'h504, 32'h04);  rd(12'h504, v); check("R3 clear", v, 32'h0);

        // R4: set and clear in the same cycle
        @(negedge clk); reg_wr_en = 1; reg_addr = 12'h504; reg_wdata = 32'h20; ch_done_in = 8'h20;
        @(negedge clk); reg_wr_en = 0; ch_done_in = '0;
        rd(12'h504, v); check("R4 set wins", v, 32'h20);

        // R5: mask write and readback
        wr(12'h520, 32'hFFFF_FFA0); rd(12'h520, v); check("R5 mask readback", v, 32'hA0);
        check("R8 combined on ch5", {31'h0, combined_done}, 1);

        // R7: masked channel blocked from peripheral
        pulse(8'h81, 8'h81);
        check("R7 periph_done blocked", {24'h0, periph_done}, 32'h01);
        check("R7 periph_active blocked", {24'h0, periph_active}, 32'h01);
        wr(12'h504, 32'h20);
        check("R8 combined held by ch7", {31'h0, combined_done}, 1);
        wr(12'h504, 32'h80);
        check("R8 combined drops", {31'h0, combined_done}, 0);
        rd(12'h504, v); check("R8 unmasked ch0 stays", v, 32'h01);

        // R9: error flag
        @(negedge clk); bus_err_in = 1;
        @(negedge clk); bus_err_in = 0;
        check("R9 err set", {31'h0, err_flag}, 1);
        wr(12'h04C, 32'h0);  rd(12'h04C, v); check("R9 zero write", v, 1);
        @(negedge clk); reg_wr_en = 1; reg_addr = 12'h04C; reg_wdata = 1; bus_err_in = 1;
        @(negedge clk); reg_wr_en = 0; bus_err_in = 0;
        check("R9 set wins", {31'h0, err_flag}, 1);
        wr(12'h04C, 32'h1);  check("R9 cleared", {31'h0, err_flag}, 0);

        // R10: unmapped and holding read
        rd(12'h100, v); check("R10 unmapped", v, 0);
        repeat (2) @(negedge clk);
        check("R10 hold", reg_rdata, 0);

        // mixed traffic, checked by the per-clock comparison
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            ch_done_in   = ($urandom % 3 == 0) ? 8'($urandom) : '0;
            ch_active_in = 8'($urandom);
            bus_err_in   = ($urandom % 11 == 0);
            reg_wr_en    = ($urandom % 4 == 0);
            reg_rd_en    = ($urandom % 2 == 0);
            case ($urandom % 4)
                0: reg_addr = 12'h504;
                1: reg_addr = 12'h520;
                2: reg_addr = 12'h04C;
                default: reg_addr = 12'h508;
            endcase
            reg_wdata = $urandom;
        end
        @(negedge clk);
        ch_done_in = '0; ch_active_in = '0; bus_err_in = 0; reg_wr_en = 0; reg_rd_en = 0;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule